// File: doc/BRIEF.md
# Segmented Image Loader

This block takes a byte stream carrying a program image and writes that image into a byte-wide target memory. The image is a series of segments placed back to back with no gaps. Each segment opens with a six-byte header: a 32-bit destination address sent least significant byte first, then a 16-bit payload length sent least significant byte first. The payload bytes follow the header. The engine writes them to the destination address, then the destination plus one, and so on for the full length.

Software gives the total image size when it pulses `start`. The engine counts every byte it takes from the stream. It stops with an error when a header or a payload would run past that size. It stops with success when the count lands exactly on the image size at a segment boundary. The stream uses a valid/ready handshake. The memory side is a single write strobe that the memory can hold off with a stall input.

Top module: `seg_image_loader`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `busy`, `done`, `error`, `in_ready` and `mem_wr_en` are all low.
- R2: A `start` pulse taken while the engine is idle latches `image_size`, clears `done` and `error`, and raises `busy` in the next cycle. A `start` that arrives while `busy` is high has no effect on the writes or the final status.
- R3: The first four header bytes form the destination address, least significant byte first. The next two bytes form the payload length, least significant byte first.
- R4: Each payload byte taken from the stream produces exactly one `mem_wr_en` cycle in that same cycle. `mem_wr_data` equals the stream byte. `mem_wr_addr` is the destination plus the byte's index within the payload, modulo 2^32.
- R5: While `mem_wr_stall` is high, `mem_wr_en` stays low and no payload byte is taken from the stream.
- R6: A segment whose length is zero writes nothing, and the next header follows straight after it.
- R7: If between 1 and 5 bytes of the image remain when a header is due, the engine ends with `done`=1 and `error`=1 and takes none of those bytes.
- R8: If a segment's length is larger than the number of image bytes left after its header, the engine ends with `done`=1 and `error`=1 and writes none of that payload.
- R9: When the count of bytes taken equals `image_size` at a segment boundary, the engine ends with `done`=1 and `error`=0. This includes an image size of zero.
- R10: Once `done` is high, `done` and `error` hold their values until the next accepted `start`. During that time `busy` and `in_ready` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load; taken only while idle |
| image_size | input | 32 | Total image bytes, latched on start |
| in_valid | input | 1 | Stream byte available |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Engine takes the stream byte this cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 8 | Memory write byte |
| mem_wr_stall | input | 1 | Memory cannot take a write this cycle |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished, held until next start |
| error | output | 1 | Load finished with a bounds error |

## Verification
The assertions assume that `start` is only a request and that it may arrive in any state. They also assume that `mem_wr_stall` may change in any cycle, including the middle of a payload. They do not assume that the stream holds a byte back once it has offered it. The stimulus drives stall and valid from a pseudo-random sequence. It pulses `start` once in the middle of a busy load. It only presents stream bytes that belong to the prepared image, so any byte the engine consumes beyond the bounds check would show up as a count mismatch.

// File: rtl/seg_image_loader.sv
module seg_image_loader #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] image_size,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  input  logic          mem_wr_stall,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam int AB = AW / 8;
  localparam int HB = (AW + LW) / 8;
  localparam int CW = $clog2(HB + 1);

  typedef enum logic [1:0] {IDLE, HDR, DATA} state_t;

  state_t        state;
  logic [SW-1:0] left;
  logic [CW-1:0] hcnt;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] len_next;
  logic          short_hdr;
  logic          take;

  assign short_hdr   = (hcnt == '0) && (left < SW'(HB));
  assign in_ready    = ((state == HDR) && !short_hdr) || ((state == DATA) && !mem_wr_stall);
  assign take        = in_valid && in_ready;
  assign mem_wr_en   = take && (state == DATA);
  assign mem_wr_addr = addr_q;
  assign mem_wr_data = in_data;
  assign busy        = (state != IDLE);
  assign len_next    = {in_data, len_q[LW-1:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      left   <= '0;
      hcnt   <= '0;
      addr_q <= '0;
      len_q  <= '0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else if (state == IDLE) begin
      if (start) begin
        state <= HDR;
        left  <= image_size;
        hcnt  <= '0;
        done  <= 1'b0;
        error <= 1'b0;
      end
    end else if (state == HDR) begin
      if (hcnt == '0 && left == '0) begin
        state <= IDLE;
        done  <= 1'b1;
      end else if (short_hdr) begin
        state <= IDLE;
        done  <= 1'b1;
        error <= 1'b1;
      end else if (take) begin
        left <= left - 1'b1;
        if (hcnt < CW'(AB))
          addr_q <= {in_data, addr_q[AW-1:8]};
        else
          len_q <= len_next;
        if (hcnt == CW'(HB - 1)) begin
          hcnt <= '0;
          if (SW'(len_next) > left - 1'b1) begin
            state <= IDLE;
            done  <= 1'b1;
            error <= 1'b1;
          end else if (len_next != '0) begin
            state <= DATA;
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end else begin
      if (take) begin
        left   <= left - 1'b1;
        addr_q <= addr_q + 1'b1;
        len_q  <= len_q - 1'b1;
        if (len_q == LW'(1)) state <= HDR;
      end
    end
  end
endmodule

// File: rtl/seg_image_loader_chk.sv
module seg_image_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_valid,
  input logic in_ready,
  input logic mem_wr_en,
  input logic mem_wr_stall,
  input logic busy,
  input logic done,
  input logic error
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !error && !in_ready && !mem_wr_en);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy && !done && !error);

  assert_write_on_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> in_valid && in_ready && busy);

  assert_no_write_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_stall |-> !mem_wr_en);

  assert_error_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done && !busy);

  assert_status_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(error));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready && !mem_wr_en);
endmodule

bind seg_image_loader seg_image_loader_chk chk_i (.*);

// File: tb/seg_image_loader_tb.sv
module seg_image_loader_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [31:0] image_size = 0;
  logic        in_valid = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready, mem_wr_en, busy, done, error;
  logic [31:0] mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic        mem_wr_stall = 0;

  always #5 clk = ~clk;

  seg_image_loader dut_i (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0]  img[$];
  logic [39:0] expw[$];
  bit          exp_err;
  int          exp_cons;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void seg(logic [31:0] a, int len, logic [7:0] base);
    for (int i = 0; i < 4; i++) img.push_back(a[8*i +: 8]);
    img.push_back(len[7:0]);
    img.push_back(len[15:8]);
    for (int i = 0; i < len; i++) img.push_back(base + 8'(i));
  endfunction

  function automatic void model(int size);
    int pos = 0;
    expw.delete();
    exp_err = 0;
    while (pos < size) begin
      logic [31:0] a;
      int len;
      if (size - pos < 6) begin exp_err = 1; break; end
      a = {img[pos+3], img[pos+2], img[pos+1], img[pos]};
      len = {img[pos+5], img[pos+4]};
      pos += 6;
      if (len > size - pos) begin exp_err = 1; break; end
      for (int i = 0; i < len; i++) expw.push_back({a + 32'(i), img[pos+i]});
      pos += len;
    end
    exp_cons = pos;
  endfunction

  task automatic load(string tag, int size, bit stall_on, bit mid_start);
    int idx = 0;
    int n = 0;
    model(size);
    @(negedge clk);
    image_size = size;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !done && !error, {tag, " R2 start"}, {37'd0, busy, done, error}, 40'd4);
    forever begin
      @(negedge clk);
      if (done) break;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_wr_stall = stall_on && lfsr[0] && lfsr[3];
      in_valid = (idx < img.size()) && !(lfsr[5] && lfsr[7]);
      in_data = (idx < img.size()) ? img[idx] : 8'h00;
      start = mid_start && (n == 4);
      n++;
      #1;
      if (mem_wr_en) begin
        if (expw.size() == 0)
          chk(0, {tag, " R4 unexpected write"}, {mem_wr_addr, mem_wr_data}, 40'd0);
        else begin
          logic [39:0] e = expw.pop_front();
          chk({mem_wr_addr, mem_wr_data} == e, {tag, " R3 R4 write"}, {mem_wr_addr, mem_wr_data}, e);
        end
        if (mem_wr_stall) chk(0, {tag, " R5 write under stall"}, 40'd1, 40'd0);
      end
      if (in_valid && in_ready) idx++;
    end
    start = 0;
    in_valid = 0;
    mem_wr_stall = 0;
    chk(error == exp_err, {tag, exp_err ? " R7 R8 error" : " R9 success"}, 40'(error), 40'(exp_err));
    chk(idx == exp_cons, {tag, " R7 R8 R9 bytes taken"}, 40'(idx), 40'(exp_cons));
    chk(expw.size() == 0, {tag, " R4 R6 R8 missing writes"}, 40'(expw.size()), 40'd0);
    repeat (5) @(negedge clk);
    chk(done && error == exp_err && !busy && !in_ready, {tag, " R10 hold"},
        {36'd0, done, error, busy, in_ready}, {36'd0, 1'b1, exp_err, 2'b00});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !in_ready && !mem_wr_en, "R1 reset",
        {35'd0, busy, done, error, in_ready, mem_wr_en}, 40'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !error, "R1 after reset", {37'd0, busy, done, error}, 40'd0);

    img.delete(); seg(32'h1234_5678, 5, 8'hA0); seg(32'hFFFF_FFFE, 3, 8'h40);
    load("T1", img.size(), 1, 1);

    img.delete(); seg(32'h0000_1000, 2, 8'h11); seg(32'h0000_2000, 0, 8'h00); seg(32'h0000_3000, 1, 8'h77);
    load("T2 R6", img.size(), 1, 0);

    img.delete(); seg(32'h0000_0040, 0, 8'h00); img.push_back(8'h01); img.push_back(8'h02); img.push_back(8'h03);
    load("T3 R7", 9, 0, 0);

    img.delete(); seg(32'h0000_0080, 10, 8'h55);
    load("T4 R8", 10, 1, 0);

    img.delete();
    load("T5 R9 empty", 0, 0, 0);

    img.delete(); seg(32'hCAFE_0000, 4, 8'hF0);
    load("T6 R9 restart", img.size(), 1, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule